// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block turns a single burst request into the series of column addresses that a double-data-rate memory uses for the data beats of one read or write. A request names a starting column, a burst length of 2, 4 or 8 beats, and an ordering. The ordering is either sequential, where the low bits count upward, or interleaved, where beat k takes the starting low bits XOR k. From the cycle after the request, the block gives one column address per clock, with a valid flag and a flag on the final beat.

The burst length fixes an aligned block of columns. Only the low bits inside that block are reordered. Every higher bit comes from the starting column and stays the same on every beat, so a burst never leaves its block. A controller can pulse a new request on the final beat and get back-to-back bursts with no gap. A request during a burst drops the rest of that burst and starts the new one.

Top module: `burst_col_seq`

## Requirements
- R1: While reset is held, and after it until the first request, `col_valid` and `col_last` are low.
- R2: A request sampled on a clock edge (`start` high) makes `col_valid` high after that edge, with `col_addr` equal to the requested `start_col`.
- R3: `burst_len` code 2'b00 gives 2 beats, 2'b01 gives 4 beats, and 2'b10 or 2'b11 gives 8 beats. Exactly that many valid beats follow a request, and `col_last` is high only on the final one.
- R4: With `order_ilv` = 0 (sequential), beat k carries low bits (s + k) mod L, where s is the starting low offset within the block and L is the length. The count wraps inside the block.
- R5: With `order_ilv` = 1 (interleaved), beat k carries low bits s XOR k.
- R6: Bits from position log2(L) upward equal those of `start_col` on every beat. No beat leaves the aligned block of L columns.
- R7: Length, ordering and starting column are captured with the request. Changes on `burst_len`, `order_ilv` and `start_col` while `start` is low have no effect on the burst in progress.
- R8: In the cycle after the final beat, `col_valid` is low unless a new request was sampled on the final beat.
- R9: A request sampled on the final beat starts the next burst in the following cycle, with no idle cycle.
- R10: A request sampled in the middle of a burst abandons the remaining beats and starts the new burst in the following cycle.
- R11: For length 2, the two orderings give the same sequence (0-1 from an even start, 1-0 from an odd start).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Burst request strobe |
| start_col | input | COL_W | Starting column address |
| burst_len | input | 2 | Length code: 00=2, 01=4, 10/11=8 |
| order_ilv | input | 1 | 0 sequential, 1 interleaved |
| col_addr | output | COL_W | Column address of the current beat |
| col_valid | output | 1 | A beat is present on `col_addr` |
| col_last | output | 1 | Current beat is the final beat of the burst |

## Verification
The assertions assume that `start` is low while reset is held. Under that assumption, every claim about the following cycle depends only on what was sampled at the edge, and not on values present before reset released. They also assume that `start_col` is stable at the edge where `start` is sampled. The stimulus changes inputs only on the falling clock edge and holds `start` low during reset. It sweeps every length code, both orderings and every low offset under several upper-bit patterns. It then scrambles `start_col`, `burst_len` and `order_ilv` while each burst runs, so the captured values are exercised under changing inputs.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  localparam int unsigned LOW_W = 3;

  typedef enum logic [1:0] {
    BLEN_2  = 2'b00,
    BLEN_4  = 2'b01,
    BLEN_8  = 2'b10,
    BLEN_8X = 2'b11
  } blen_code_e;

  typedef struct packed {
    blen_code_e    blen;
    logic          ilv;
  } burst_cfg_t;

  function automatic logic [LOW_W-1:0] blk_mask(input blen_code_e c);
    case (c)
      BLEN_2:  blk_mask = 3'b001;
      BLEN_4:  blk_mask = 3'b011;
      default: blk_mask = 3'b111;
    endcase
  endfunction

  function automatic logic [LOW_W-1:0] seq_low(input logic [LOW_W-1:0] s,
                                               input logic [LOW_W-1:0] k,
                                               input logic [LOW_W-1:0] m);
    seq_low = (s + k) & m;
  endfunction

  function automatic logic [LOW_W-1:0] ilv_low(input logic [LOW_W-1:0] s,
                                               input logic [LOW_W-1:0] k,
                                               input logic [LOW_W-1:0] m);
    ilv_low = (s ^ k) & m;
  endfunction

endpackage

// File: rtl/burst_beat_ctrl.sv
module burst_beat_ctrl
  import burst_seq_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [COL_W-1:0]     start_col,
  input  burst_cfg_t           cfg_in,
  output logic [COL_W-1:0]     base_col,
  output burst_cfg_t           cfg_q,
  output logic [LOW_W-1:0]     beat,
  output logic                 active,
  output logic                 burst_end
);

  logic [LOW_W-1:0] mask_q;
  logic             burst_launch;
  logic             beat_adv;

  assign mask_q       = blk_mask(cfg_q.blen);
  assign burst_launch = start;
  assign burst_end    = active && (beat == mask_q);
  assign beat_adv     = active && !burst_end && !burst_launch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_col <= '0;
      cfg_q    <= '{blen: BLEN_2, ilv: 1'b0};
      beat     <= '0;
      active   <= 1'b0;
    end else if (burst_launch) begin
      base_col <= start_col;
      cfg_q    <= cfg_in;
      beat     <= '0;
      active   <= 1'b1;
    end else if (beat_adv) begin
      beat     <= beat + 1'b1;
    end else if (burst_end) begin
      active   <= 1'b0;
      beat     <= '0;
    end
  end

  // R3
  beat_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> ((beat & ~mask_q) == '0));

  // R7
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !burst_launch && !burst_end) |=> (cfg_q == $past(cfg_q)) && (base_col == $past(base_col)));

endmodule

// File: rtl/burst_col_map.sv
module burst_col_map
  import burst_seq_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic [COL_W-1:0]  base_col,
  input  burst_cfg_t        cfg,
  input  logic [LOW_W-1:0]  beat,
  output logic [COL_W-1:0]  col_out
);

  logic [LOW_W-1:0] mask;
  logic [LOW_W-1:0] s_low;
  logic [LOW_W-1:0] new_low;

  assign mask  = blk_mask(cfg.blen);
  assign s_low = base_col[LOW_W-1:0];

  always_comb begin
    if (cfg.ilv) new_low = ilv_low(s_low, beat, mask);
    else         new_low = seq_low(s_low, beat, mask);
  end

  generate
    if (COL_W > LOW_W) begin : g_upper
      assign col_out = {base_col[COL_W-1:LOW_W], (s_low & ~mask) | new_low};
    end else begin : g_flat
      assign col_out = (s_low & ~mask) | new_low;
    end
  endgenerate

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import burst_seq_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic [1:0]       burst_len,
  input  logic             order_ilv,
  output logic [COL_W-1:0] col_addr,
  output logic             col_valid,
  output logic             col_last
);

  burst_cfg_t       cfg_in;
  burst_cfg_t       cfg_q;
  logic [COL_W-1:0] base_col;
  logic [LOW_W-1:0] beat;
  logic             active;
  logic             burst_end;
  logic [COL_W-1:0] mapped_col;

  assign cfg_in.blen = blen_code_e'(burst_len);
  assign cfg_in.ilv  = order_ilv;

  burst_beat_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .start_col (start_col),
    .cfg_in    (cfg_in),
    .base_col  (base_col),
    .cfg_q     (cfg_q),
    .beat      (beat),
    .active    (active),
    .burst_end (burst_end)
  );

  burst_col_map #(.COL_W(COL_W)) u_map (
    .base_col (base_col),
    .cfg      (cfg_q),
    .beat     (beat),
    .col_out  (mapped_col)
  );

  assign col_addr  = mapped_col;
  assign col_valid = active;
  assign col_last  = burst_end;

  // R2
  first_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> col_valid && (col_addr == $past(start_col)));

  // R3
  last_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_last |-> col_valid);

  // R6
  upper_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && !col_last && !start) |=> (col_addr[COL_W-1:LOW_W] == $past(col_addr[COL_W-1:LOW_W])));

  // R8
  idle_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (col_last && !start) |=> !col_valid);

  // R3
  burst_continue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && !col_last && !start) |=> col_valid);

endmodule

// File: tb/test_burst_col_seq.sv
module test_burst_col_seq;

  localparam int COL_W = 10;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [COL_W-1:0] start_col = '0;
  logic [1:0]       burst_len = 2'b00;
  logic             order_ilv = 1'b0;
  logic [COL_W-1:0] col_addr;
  logic             col_valid;
  logic             col_last;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  burst_col_seq #(.COL_W(COL_W)) i_burst_col_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
    .burst_len(burst_len), .order_ilv(order_ilv),
    .col_addr(col_addr), .col_valid(col_valid), .col_last(col_last)
  );

  function automatic int len_of(input int code);
    return (code == 0) ? 2 : (code == 1) ? 4 : 8;
  endfunction

  function automatic int expect_col(input int s, input int code, input int ilv, input int k);
    int l = len_of(code);
    int off = s % l;
    int blk = s - off;
    if (ilv != 0) return blk + (off ^ k);
    return blk + ((off + k) % l);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic launch(input int s, input int code, input int ilv);
    start = 1'b1;
    start_col = COL_W'(s);
    burst_len = 2'(code);
    order_ilv = ilv[0];
  endtask

  // checks beats from the first sampled beat; leaves at negedge of final beat
  task automatic follow(input int s, input int code, input int ilv, input string req);
    int l = len_of(code);
    for (int k = 0; k < l; k++) begin
      @(negedge clk);
      if (k == 0) begin
        start = 1'b0;
        start_col = ~start_col;
        burst_len = ~burst_len;
        order_ilv = ~order_ilv;
      end
      check({req, " addr"}, int'(col_addr), expect_col(s, code, ilv, k));
      check("R3 valid", int'(col_valid), 1);
      check("R3 last", int'(col_last), (k == l - 1) ? 1 : 0);
    end
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int hi_pat[3] = '{0, 16'h55, 16'h7F};
    repeat (3) @(negedge clk);
    check("R1 valid in reset", int'(col_valid), 0);
    check("R1 last in reset", int'(col_last), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid after reset", int'(col_valid), 0);
    check("R1 last after reset", int'(col_last), 0);

    // R4 R5 R6 R7 sweep: every length code, ordering, low offset
    for (int code = 0; code < 4; code++)
      for (int ilv = 0; ilv < 2; ilv++)
        for (int h = 0; h < 3; h++)
          for (int lo = 0; lo < 8; lo++) begin
            int s = (hi_pat[h] << 3) | lo;
            launch(s, code, ilv);
            follow(s, code, ilv, ilv ? "R5 R6 R7" : "R4 R6 R7");
            @(negedge clk);
            check("R8 idle after last", int'(col_valid), 0);
          end

    // R11: length 2 orderings agree at the port
    for (int lo = 0; lo < 2; lo++) begin
      int seqv[2];
      for (int ilv = 0; ilv < 2; ilv++) begin
        launch(16'h120 | lo, 0, ilv);
        @(negedge clk); start = 1'b0;
        seqv[0] = int'(col_addr);
        @(negedge clk);
        seqv[1] = int'(col_addr);
        check("R11 beat0", seqv[0], 16'h120 | lo);
        check("R11 beat1", seqv[1], 16'h120 | (lo ^ 1));
        @(negedge clk);
      end
    end

    // R9: request on final beat chains with no gap
    launch(16'h0D, 2, 0);
    follow(16'h0D, 2, 0, "R9 first");
    launch(16'h3A, 1, 1);
    follow(16'h3A, 1, 1, "R9 chained");
    launch(16'h201, 0, 0);
    follow(16'h201, 0, 0, "R9 chained2");
    @(negedge clk);
    check("R8 idle after chain", int'(col_valid), 0);

    // R10: request mid-burst restarts
    launch(16'h45, 2, 1);
    @(negedge clk); start = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R10 pre-restart addr", int'(col_addr), expect_col(16'h45, 2, 1, 2));
    launch(16'h1F2, 1, 0);
    follow(16'h1F2, 1, 0, "R10 restarted");
    @(negedge clk);
    check("R10 idle after restarted burst", int'(col_valid), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule